// File: doc/BRIEF.md
# Four-Plane Display Memory Write Path

This block sits between a byte-wide CPU port and four 8-bit display memory planes that share one address. Each pixel's 4-bit color index takes bit 0 from plane 0 up to bit 3 from plane 3. A CPU write either broadcasts the CPU byte to the planes that a plane mask enables, or stores back four bytes captured earlier. A CPU read fetches the addressed byte of all four planes at once. It keeps all four in internal latches and returns one of them to the CPU.

The latch-copy write mode lets software move a four-plane block with one read and one write per byte, where a broadcast write would need four passes. The plane mask, an 8-bit graphics mode register (its low two bits are the write mode) and a plane selector for reads are loaded through a small configuration port. The plane memories are external. They have synchronous reads with one cycle of latency.

A controller with five states runs the CPU side: IDLE, READ, CAPTURE, RESPOND and WRITE. The transitions are:
- IDLE→READ on an accepted read.
- READ→CAPTURE always, while the planes are being read.
- CAPTURE→RESPOND always, loading the latches.
- RESPOND→IDLE always, returning the byte.
- IDLE→WRITE on an accepted write.
- WRITE→IDLE always, storing to the planes.

Top module: `planar_write_path`

## Requirements
- R1: After reset the plane mask is 4'hF, the graphics mode register is 8'h00, the read plane selector is 0, `cpu_ready` is 1 and `cpu_done` is 0.
- R2: In write mode 0 the CPU byte is stored unchanged into every plane i whose mask bit i is 1. Plane i uses bits [8i+7:8i] of the plane data buses.
- R3: For every one of the 16 mask values, a plane whose mask bit is 0 keeps its stored byte on a CPU write.
- R4: A CPU read loads the addressed byte of all four planes into four latches and returns the latch of the plane named by the read selector (config select 3, data bits 1:0).
- R5: In write mode 1 a CPU write stores latch i into plane i at the write address for each enabled plane, and the CPU data byte has no effect.
- R6: Config select 1 loads all 8 bits of the graphics mode register. Config select 2 loads only bits 1:0 from data bits 1:0 and leaves bits 7:2 unchanged. Config select 0 loads the mask from data bits 3:0. The register is visible on `gfx_mode`.
- R7: Write modes 2 and 3 behave exactly as write mode 0.
- R8: A write is accepted only when `cpu_ready` is 1 and reaches the planes in the next cycle, with `cpu_done` high in that cycle. For a read, `cpu_done` and valid `cpu_rdata` come three cycles after acceptance. Requests made while `cpu_ready` is 0 are ignored.
- R9: The latches change only on a CPU read, so several latch-copy writes after one read all store the same bytes, even if the source address has been overwritten since.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | CPU byte address within the planes |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_ready | output | 1 | Controller idle and accepting a request |
| cpu_done | output | 1 | Write committed or read data valid |
| cpu_rdata | output | 8 | Selected plane latch |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | 0 mask, 1 mode register, 2 write-mode field, 3 read selector |
| cfg_wdata | input | 8 | Configuration data |
| gfx_mode | output | 8 | Graphics mode register contents |
| pl_en | output | PLANES | Per-plane access enable |
| pl_we | output | PLANES | Per-plane write enable |
| pl_addr | output | ADDR_W | Shared plane address |
| pl_wdata | output | PLANES*8 | Plane write data, plane i at [8i+7:8i] |
| pl_rdata | input | PLANES*8 | Plane read data, one cycle after enable |

## Verification
A latch that loads at the wrong moment or from the wrong lane would only show up on the next latch-copy write. There it appears as wrong bytes in one or more planes, possibly many cycles later, so the bench checks every plane after each copy. A mask decode fault shows at once as a changed byte in a plane that should have been left alone, or an unchanged byte in one that should have been written. A controller stuck outside IDLE shows as `cpu_ready` held low. An extra or missing state shifts `cpu_done` by a cycle on the very next access.

// File: rtl/plane_wr_pkg.sv
package plane_wr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CAPTURE,
        ST_RESPOND,
        ST_WRITE
    } ctl_state_e;

    typedef enum logic [1:0] {
        CFG_MASK       = 2'd0,
        CFG_MODE_ALL   = 2'd1,
        CFG_MODE_FIELD = 2'd2,
        CFG_RMAP       = 2'd3
    } cfg_sel_e;

    localparam logic [1:0] WMODE_LATCH_COPY = 2'd1;

endpackage

// File: rtl/plane_cfg_regs.sv
module plane_cfg_regs
    import plane_wr_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(PLANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [PLANES-1:0] plane_mask,
    output logic [DATA_W-1:0] mode_reg,
    output logic [SEL_W-1:0]  rmap_sel
);

    cfg_sel_e sel;
    assign sel = cfg_sel_e'(cfg_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plane_mask <= '1;
            mode_reg   <= '0;
            rmap_sel   <= '0;
        end else if (cfg_we) begin
            unique case (sel)
                CFG_MASK:       plane_mask    <= cfg_wdata[PLANES-1:0];
                CFG_MODE_ALL:   mode_reg      <= cfg_wdata;
                CFG_MODE_FIELD: mode_reg[1:0] <= cfg_wdata[1:0];
                CFG_RMAP:       rmap_sel      <= cfg_wdata[SEL_W-1:0];
                default: ;
            endcase
        end
    end

    // R6: a field-only write never disturbs the upper mode bits
    assert_field_keeps_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && sel == CFG_MODE_FIELD) |=> (mode_reg[DATA_W-1:2] == $past(mode_reg[DATA_W-1:2])));

    // R6: no config write leaves the whole mode register stable
    assert_mode_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && (sel == CFG_MODE_ALL || sel == CFG_MODE_FIELD)) |=> $stable(mode_reg));

endmodule

// File: rtl/plane_latch_bank.sv
module plane_latch_bank #(
    parameter int PLANES = 4,
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(PLANES),
    localparam int BUS_W = PLANES * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BUS_W-1:0]  rd_bus,
    input  logic [SEL_W-1:0]  rmap_sel,
    output logic [BUS_W-1:0]  latch_bus,
    output logic [DATA_W-1:0] sel_byte
);

    for (genvar p = 0; p < PLANES; p++) begin : g_latch
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                latch_bus[p*DATA_W +: DATA_W] <= '0;
            end else if (load) begin
                latch_bus[p*DATA_W +: DATA_W] <= rd_bus[p*DATA_W +: DATA_W];
            end
        end
    end

    assign sel_byte = latch_bus[rmap_sel*DATA_W +: DATA_W];

    // R4: a load captures every plane lane
    assert_latch_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (latch_bus == $past(rd_bus)));

    // R9: without a load the latches hold
    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(latch_bus));

endmodule

// File: rtl/plane_write_mux.sv
module plane_write_mux
    import plane_wr_pkg::*;
#(
    parameter int PLANES = 4,
    parameter int DATA_W = 8,
    localparam int BUS_W = PLANES * DATA_W
) (
    input  logic              wr_strobe,
    input  logic [1:0]        wmode,
    input  logic [PLANES-1:0] plane_mask,
    input  logic [DATA_W-1:0] cpu_byte,
    input  logic [BUS_W-1:0]  latch_bus,
    output logic [PLANES-1:0] pl_we,
    output logic [BUS_W-1:0]  pl_wdata
);

    logic use_latch;
    assign use_latch = (wmode == WMODE_LATCH_COPY);

    for (genvar p = 0; p < PLANES; p++) begin : g_lane
        always_comb begin
            pl_we[p] = wr_strobe & plane_mask[p];
            if (use_latch) begin
                pl_wdata[p*DATA_W +: DATA_W] = latch_bus[p*DATA_W +: DATA_W];
            end else begin
                pl_wdata[p*DATA_W +: DATA_W] = cpu_byte;
            end
        end
    end

endmodule

// File: rtl/planar_write_path.sv
module planar_write_path
    import plane_wr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PLANES = 4,
    parameter int DATA_W = 8,
    localparam int SEL_W = $clog2(PLANES),
    localparam int BUS_W = PLANES * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] gfx_mode,
    output logic [PLANES-1:0] pl_en,
    output logic [PLANES-1:0] pl_we,
    output logic [ADDR_W-1:0] pl_addr,
    output logic [BUS_W-1:0]  pl_wdata,
    input  logic [BUS_W-1:0]  pl_rdata
);

    ctl_state_e state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    logic [PLANES-1:0] plane_mask;
    logic [SEL_W-1:0]  rmap_sel;
    logic [BUS_W-1:0]  latch_bus;
    logic [DATA_W-1:0] sel_byte;
    logic              latch_load;
    logic              wr_strobe;
    logic              accept;

    assign accept = cpu_req && (state_q == ST_IDLE);

    plane_cfg_regs #(.PLANES(PLANES), .DATA_W(DATA_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .plane_mask (plane_mask),
        .mode_reg   (gfx_mode),
        .rmap_sel   (rmap_sel)
    );

    plane_latch_bank #(.PLANES(PLANES), .DATA_W(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (latch_load),
        .rd_bus    (pl_rdata),
        .rmap_sel  (rmap_sel),
        .latch_bus (latch_bus),
        .sel_byte  (sel_byte)
    );

    plane_write_mux #(.PLANES(PLANES), .DATA_W(DATA_W)) u_wmux (
        .wr_strobe  (wr_strobe),
        .wmode      (gfx_mode[1:0]),
        .plane_mask (plane_mask),
        .cpu_byte   (wdata_q),
        .latch_bus  (latch_bus),
        .pl_we      (pl_we),
        .pl_wdata   (pl_wdata)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                addr_q  <= cpu_addr;
                wdata_q <= cpu_wdata;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (cpu_req) state_d = cpu_we ? ST_WRITE : ST_READ;
            end
            ST_READ:    state_d = ST_CAPTURE;
            ST_CAPTURE: state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
            ST_WRITE:   state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_ready  = 1'b0;
        cpu_done   = 1'b0;
        pl_en      = '0;
        latch_load = 1'b0;
        wr_strobe  = 1'b0;
        unique case (state_q)
            ST_IDLE:    cpu_ready = 1'b1;
            ST_READ:    pl_en = '1;
            ST_CAPTURE: latch_load = 1'b1;
            ST_RESPOND: cpu_done = 1'b1;
            ST_WRITE: begin
                wr_strobe = 1'b1;
                pl_en     = plane_mask;
                cpu_done  = 1'b1;
            end
            default: ;
        endcase
    end

    assign pl_addr   = addr_q;
    assign cpu_rdata = sel_byte;

    // R8: read data valid three cycles after acceptance
    assert_read_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !cpu_we) |-> ##3 cpu_done);

    // R8: write commits in the next cycle
    assert_write_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && cpu_we) |=> (cpu_done && !cpu_ready));

    // R3: no plane outside the mask is ever written
    assert_we_in_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pl_we & ~plane_mask) == '0));

    // R8: completion only while busy
    assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !cpu_ready);

endmodule

// File: tb/planar_write_path_tb.sv
module planar_write_path_tb;

    localparam int AW = 8;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic cpu_ready, cpu_done;
    logic [7:0] cpu_rdata;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] gfx_mode;
    logic [NP-1:0] pl_en, pl_we;
    logic [AW-1:0] pl_addr;
    logic [NP*8-1:0] pl_wdata, pl_rdata;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    planar_write_path #(.ADDR_W(AW), .PLANES(NP), .DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .gfx_mode(gfx_mode),
        .pl_en(pl_en), .pl_we(pl_we), .pl_addr(pl_addr),
        .pl_wdata(pl_wdata), .pl_rdata(pl_rdata)
    );

    // plane memory model: synchronous, one cycle read latency
    logic [7:0] mem [NP][256];
    for (genvar p = 0; p < NP; p++) begin : g_mem
        always_ff @(posedge clk) begin
            if (pl_en[p]) begin
                if (pl_we[p]) mem[p][pl_addr] <= pl_wdata[p*8 +: 8];
                else          pl_rdata[p*8 +: 8] <= mem[p][pl_addr];
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cpu_write(input logic [AW-1:0] a, input logic [7:0] d, output bit done_seen);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_req = 1'b0;
        done_seen = cpu_done;
        @(negedge clk);
    endtask

    task automatic cpu_read(input logic [AW-1:0] a, output logic [7:0] d, output int lat);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
        lat = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            cpu_req = 1'b0;
            lat++;
            if (cpu_done) break;
        end
        d = cpu_rdata;
        @(negedge clk);
    endtask

    // mode 0 and a single-plane mask: plane p gets v[p]
    task automatic preload(input logic [AW-1:0] a, input logic [31:0] v);
        bit dn;
        for (int p = 0; p < NP; p++) begin
            cfg(2'd0, 8'(1 << p));
            cpu_write(a, v[p*8 +: 8], dn);
        end
        cfg(2'd0, 8'h0F);
    endtask

    task automatic t_reset;
        logic [7:0] d; int lat; bit dn;
        chk(cpu_ready == 1'b1, "R1 ready after reset", 32'(cpu_ready), 1);
        chk(cpu_done == 1'b0, "R1 done low after reset", 32'(cpu_done), 0);
        chk(gfx_mode == 8'h00, "R1 mode register reset", 32'(gfx_mode), 0);
        cpu_write(8'h10, 8'hA5, dn);
        for (int p = 0; p < NP; p++)
            chk(mem[p][8'h10] == 8'hA5, "R1 R2 default mask writes all planes", 32'(mem[p][8'h10]), 32'hA5);
        preload(8'h11, 32'h44332211);
        cpu_read(8'h11, d, lat);
        chk(d == 8'h11, "R1 default read selector plane 0", 32'(d), 32'h11);
    endtask

    task automatic t_mask_combos;
        bit dn;
        logic [7:0] exp;
        for (int m = 0; m < 16; m++) begin
            preload(8'(8'h60 + m), {8'(8'h40 + m), 8'(8'h30 + m), 8'(8'h20 + m), 8'(8'h10 + m)});
            cfg(2'd0, 8'(m));
            cpu_write(8'(8'h60 + m), 8'(8'hC0 | m), dn);
            for (int p = 0; p < NP; p++) begin
                exp = m[p] ? 8'(8'hC0 | m) : 8'(8'h10 * (p + 1) + m);
                chk(mem[p][8'h60 + m] == exp, m[p] ? "R2 enabled plane written" : "R3 disabled plane kept",
                    32'(mem[p][8'h60 + m]), 32'(exp));
            end
        end
        cfg(2'd0, 8'h0F);
    endtask

    task automatic t_read_map;
        logic [7:0] d; int lat;
        preload(8'h20, 32'h44332211);
        for (int s = 0; s < NP; s++) begin
            cfg(2'd3, 8'(s));
            cpu_read(8'h20, d, lat);
            chk(d == 8'(8'h11 * (s + 1)), "R4 read selector picks plane", 32'(d), 32'(8'h11 * (s + 1)));
        end
        cfg(2'd3, 8'h00);
    endtask

    task automatic t_latch_copy;
        logic [7:0] d; int lat; bit dn;
        preload(8'h30, 32'hD4C3B2A1);
        preload(8'h41, 32'h99999999);
        cpu_read(8'h30, d, lat);
        cfg(2'd2, 8'h01);
        cpu_write(8'h40, 8'hFF, dn);
        for (int p = 0; p < NP; p++)
            chk(mem[p][8'h40] == 8'(32'hD4C3B2A1 >> (8 * p)), "R5 latch copy ignores cpu byte",
                32'(mem[p][8'h40]), 32'hD4C3B2A1 >> (8 * p));
        cfg(2'd0, 8'h05);
        cpu_write(8'h41, 8'h00, dn);
        for (int p = 0; p < NP; p++)
            chk(mem[p][8'h41] == ((p % 2 == 0) ? 8'(32'hD4C3B2A1 >> (8 * p)) : 8'h99),
                "R5 mask gates latch copy", 32'(mem[p][8'h41]),
                (p % 2 == 0) ? (32'hD4C3B2A1 >> (8 * p)) & 32'hFF : 32'h99);
        // overwrite the source, then copy again without a new read
        cfg(2'd2, 8'h00);
        cfg(2'd0, 8'h0F);
        cpu_write(8'h30, 8'h00, dn);
        cfg(2'd2, 8'h01);
        cpu_write(8'h42, 8'h5A, dn);
        for (int p = 0; p < NP; p++)
            chk(mem[p][8'h42] == 8'(32'hD4C3B2A1 >> (8 * p)), "R9 latches hold until next read",
                32'(mem[p][8'h42]), (32'hD4C3B2A1 >> (8 * p)) & 32'hFF);
        cfg(2'd2, 8'h00);
    endtask

    task automatic t_mode_reg;
        bit dn;
        cfg(2'd1, 8'hC4);
        chk(gfx_mode == 8'hC4, "R6 full mode write", 32'(gfx_mode), 32'hC4);
        cfg(2'd2, 8'hFD);
        chk(gfx_mode == 8'hC5, "R6 field write keeps upper bits", 32'(gfx_mode), 32'hC5);
        cfg(2'd2, 8'h02);
        chk(gfx_mode == 8'hC6, "R6 field write mode 2", 32'(gfx_mode), 32'hC6);
        cpu_write(8'h50, 8'h3C, dn);
        for (int p = 0; p < NP; p++)
            chk(mem[p][8'h50] == 8'h3C, "R7 mode 2 acts as mode 0", 32'(mem[p][8'h50]), 32'h3C);
        cfg(2'd2, 8'h03);
        cpu_write(8'h51, 8'hE7, dn);
        for (int p = 0; p < NP; p++)
            chk(mem[p][8'h51] == 8'hE7, "R7 mode 3 acts as mode 0", 32'(mem[p][8'h51]), 32'hE7);
        cfg(2'd1, 8'h00);
    endtask

    task automatic t_timing;
        logic [7:0] d; int lat; bit dn;
        preload(8'h70, 32'h04030201);
        preload(8'h71, 32'h55555555);
        cpu_write(8'h72, 8'h12, dn);
        chk(dn == 1'b1, "R8 write done next cycle", 32'(dn), 1);
        cpu_read(8'h70, d, lat);
        chk(lat == 3, "R8 read latency", 32'(lat), 3);
        chk(d == 8'h01, "R8 read data", 32'(d), 1);
        // request a write while a read is in flight
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 8'h70;
        @(negedge clk);
        chk(cpu_ready == 1'b0, "R8 busy during read", 32'(cpu_ready), 0);
        cpu_we = 1'b1; cpu_addr = 8'h71; cpu_wdata = 8'hEE;
        @(negedge clk);
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
        chk(cpu_done == 1'b1, "R8 read completes despite extra request", 32'(cpu_done), 1);
        @(negedge clk);
        @(negedge clk);
        for (int p = 0; p < NP; p++)
            chk(mem[p][8'h71] == 8'h55, "R8 busy request ignored", 32'(mem[p][8'h71]), 32'h55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_combos();
        t_read_map();
        t_latch_copy();
        t_mode_reg();
        t_timing();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule